// File: doc/BRIEF.md
# Multi-Channel Rate-Matching Sample Repeater

This block sits behind eight parallel decimating channels, each of which delivers new samples at its own reduced rate. It holds every channel's newest sample and presents all enabled channels together on one common output strobe. That strobe runs at the rate of the fastest enabled channel, so a slower channel repeats its held sample until a fresh one arrives. The output strobe comes from counting a common input-sample strobe: one output pulse for every `m` input strobes, where `m` is the smallest decimation factor among the enabled channels.

The block registers the enables and the 16-bit decimation factors. It checks that the combination is legal and derives a 14-bit repeat factor for each channel, which can be read back. Channels may mix factors freely while every enabled factor is a power of two. Once any enabled factor carries a base of 3 or 5, every enabled channel must use that same factor. After a configuration change, the outputs stay quiet for one cycle. An illegal configuration keeps all outputs at zero and raises an error flag.

Top module: `chan_rate_aligner`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it, `out_valid`, `out_data`, `rep_factor` and `cfg_error` are all zero until a configuration is applied.
- R2: An enabled channel whose factor is outside {2, 3, 4, 5, 6, 8, 10, 12, 16, 20, 24, 32, 40, 48, 64, 80, 96, 128, 256, ..., 32768 (every power of two from 2 to 32768)} makes the configuration illegal. The factor of a disabled channel is not checked.
- R3: Enabled channels may hold different factors only when all enabled factors are powers of two. If any enabled factor is 3·2^k or 5·2^k and the enabled factors are not all equal, the configuration is illegal.
- R4: For a legal configuration, `rep_factor[c]` is channel c's factor divided by the smallest enabled factor. The fastest channel reads 1. A disabled channel, and every channel of an illegal configuration, reads 0. The value can be read from the first cycle after the new configuration is registered.
- R5: A configuration whose repeat factor would not fit in 14 bits (a ratio of 16384) is illegal. A ratio of 8192 is legal.
- R6: When `ch_en` or `dec_factor` changes, the next clock edge registers it. For the following cycle, `out_valid` and `out_data` are zero and strobes and input samples are ignored. Held samples restart from zero.
- R7: With a legal configuration and at least one enabled channel, `out_valid` pulses for one cycle after every m-th sampled `in_stb` high, where m is the smallest enabled factor. Counting starts at the first strobe after the reconfiguration window.
- R8: On each output pulse, every enabled channel presents the newest sample captured before that edge. Between pulses it holds its value and repeats it until a new sample is captured. A sample that arrives on the pulse edge appears on the next pulse.
- R9: A disabled channel has `out_valid[c]` and `out_data[c]` at zero, and its `in_valid` is ignored.
- R10: `cfg_error` is set from the cycle after an illegal configuration is registered. While the configuration stays illegal, `out_valid` and `out_data` remain zero. A legal configuration clears the flag one cycle after it is registered.
- R11: With no channel enabled, `out_valid` never pulses, whatever `in_stb` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_en | input | 8 | Per-channel enable |
| dec_factor | input | 8x16 | Per-channel decimation factor |
| in_valid | input | 8 | New decimated sample on the channel |
| in_data | input | 8x16 | Per-channel decimated sample |
| in_stb | input | 1 | Common input-sample strobe |
| out_valid | output | 8 | Rate-matched output strobe per channel |
| out_data | output | 8x16 | Rate-matched output sample per channel |
| rep_factor | output | 8x14 | Readback of each channel's repeat factor |
| cfg_error | output | 1 | Configuration is illegal |

## Verification
Some properties are checked on every cycle. For each enabled channel, the repeat factor multiplied by the minimum factor rebuilds the channel's own factor. A non-power-of-two factor must equal the minimum. Disabled lanes stay silent and hold zero. Lanes do not change value between pulses. The reconfiguration window and the error state are quiet. Every output pulse follows a strobe, and the strobe counter stays below its divisor.

Other behaviours show only in the bench scenarios. These are the exact legality verdicts for base-3, base-5, out-of-set and over-range mixes, and the pulse count over a run of strobes. They also include which sample a lane repeats when a capture and a pulse share an edge, and the cleared samples after a reconfiguration.

// File: rtl/rmr_pkg.sv
// Shared constants and helper functions for the rate-matching repeater.
// Assumes factors are unsigned 16-bit values and repeat factors are 14 bits wide.
package rmr_pkg;
    localparam int FAC_W   = 16;
    localparam int REP_W   = 14;
    localparam int LG_W    = $clog2(FAC_W);
    localparam int MAX_SH3 = 5;   // 3 * 2^k legal up to k = 5 (96)
    localparam int MAX_SH5 = 4;   // 5 * 2^k legal up to k = 4 (80)

    // True when exactly one bit is set.
    function automatic logic is_pow2(input logic [FAC_W-1:0] f);
        return (f != '0) && ((f & (f - 1'b1)) == '0);
    endfunction

    // True when f belongs to the set of supported decimation factors.
    function automatic logic fac_legal(input logic [FAC_W-1:0] f);
        logic ok;
        ok = is_pow2(f) && (f != FAC_W'(1));
        for (int k = 0; k <= MAX_SH3; k++)
            if (f == FAC_W'(3 << k)) ok = 1'b1;
        for (int k = 0; k <= MAX_SH5; k++)
            if (f == FAC_W'(5 << k)) ok = 1'b1;
        return ok;
    endfunction

    // Index of the highest set bit (log2 for a power of two).
    function automatic logic [LG_W-1:0] top_bit(input logic [FAC_W-1:0] f);
        logic [LG_W-1:0] p;
        p = '0;
        for (int i = 0; i < FAC_W; i++)
            if (f[i]) p = LG_W'(i);
        return p;
    endfunction
endpackage

// File: rtl/rmr_cfg_check.sv
// Configuration analyser: decides legality, finds the smallest enabled factor
// and derives each channel's repeat factor. Purely combinational; the clock
// and reset only qualify the embedded assertions.
// Assumes the enables and factors are stable registered values.
module rmr_cfg_check
    import rmr_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH-1:0]             en,
    input  logic [NCH-1:0][FAC_W-1:0]  fac,
    output logic                       legal,
    output logic                       any_en,
    output logic [FAC_W-1:0]           min_fac,
    output logic [NCH-1:0][REP_W-1:0]  rep
);
    logic                  all_p2;
    logic                  bad;
    logic [LG_W-1:0]       sh;
    logic [FAC_W-1:0]      ratio;

    // Scan enabled channels for minimum, legality and the resulting ratios.
    always_comb begin
        min_fac = '1;
        any_en  = 1'b0;
        all_p2  = 1'b1;
        bad     = 1'b0;
        ratio   = '0;
        for (int c = 0; c < NCH; c++) begin
            if (en[c]) begin
                any_en = 1'b1;
                if (fac[c] < min_fac) min_fac = fac[c];
                if (!is_pow2(fac[c]))  all_p2  = 1'b0;
                if (!fac_legal(fac[c])) bad    = 1'b1;
            end
        end
        sh = top_bit(min_fac);
        for (int c = 0; c < NCH; c++) begin
            if (en[c]) begin
                if (!all_p2 && fac[c] != min_fac) bad = 1'b1;
                ratio = all_p2 ? (fac[c] >> sh) : FAC_W'(1);
                if (ratio[FAC_W-1:REP_W] != '0) bad = 1'b1;
            end
        end
        legal = !bad;
        for (int c = 0; c < NCH; c++) begin
            ratio  = all_p2 ? (fac[c] >> sh) : FAC_W'(1);
            rep[c] = (en[c] && !bad) ? ratio[REP_W-1:0] : '0;
        end
    end

    logic [NCH-1:0] is_one;
    // Marks lanes that read back a repeat factor of one (assertion helper).
    always_comb
        for (int c = 0; c < NCH; c++) is_one[c] = en[c] && (rep[c] == REP_W'(1));

    p_fastest_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (legal && any_en) |-> ($countones(is_one) >= 1))
        else $error("fastest channel lacks repeat factor 1");

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        p_rep_rebuilds_fac_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (legal && en[c]) |-> ((32'(rep[c]) * 32'(min_fac)) == 32'(fac[c])))
            else $error("repeat times minimum differs from factor");
        p_off_rep_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !en[c] |-> (rep[c] == '0))
            else $error("disabled channel reports nonzero repeat");
        p_base_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (legal && en[c] && !is_pow2(fac[c])) |-> (fac[c] == min_fac))
            else $error("base 3/5 factor differs from minimum on legal config");
    end
endmodule

// File: rtl/rmr_stb_div.sv
// Output-strobe divider: counts the common input strobe and fires once per
// div strobes. Assumes div >= 2 whenever run is high and div changes only
// together with clr.
module rmr_stb_div
    import rmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    input  logic              in_stb,
    input  logic [FAC_W-1:0]  div,
    output logic              fire
);
    logic [FAC_W-1:0] cnt;

    // Fire on the strobe that completes a group of div strobes.
    assign fire = in_stb && run && !clr && (cnt == div - 1'b1);

    // Advance the strobe count, wrapping on fire and restarting on clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)          cnt <= '0;
        else if (in_stb && run)     cnt <= fire ? '0 : cnt + 1'b1;
    end

    p_cnt_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr) |-> (cnt < div))
        else $error("strobe count reached divisor");
endmodule

// File: rtl/rmr_lane.sv
// One output lane: holds the newest decimated sample and presents it on each
// output pulse. Assumes fire is already gated by legality and reconfiguration.
module rmr_lane #(
    parameter int SMP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              quiet,
    input  logic              en,
    input  logic              fire,
    input  logic              in_vld,
    input  logic [SMP_W-1:0]  in_smp,
    output logic              out_vld,
    output logic [SMP_W-1:0]  out_smp
);
    logic [SMP_W-1:0] held;

    // Capture the newest sample of an enabled lane; restart on reconfiguration.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)       held <= '0;
        else if (en && in_vld)   held <= in_smp;
    end

    // Drive the lane output: zero when silenced, load on pulse, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || quiet || !en) begin
            out_smp <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= fire;
            if (fire) out_smp <= held;
        end
    end

    p_off_lane_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (out_smp == '0 && !out_vld))
        else $error("disabled lane not silent");
    p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && !$past(fire) && !$past(clr) && !$past(quiet)) |-> $stable(out_smp))
        else $error("lane value moved between pulses");
endmodule

// File: rtl/chan_rate_aligner.sv
// Top of the rate-matching repeater. Registers the configuration, opens a
// one-cycle quiet window on every change, latches the error state and ties
// the analyser, strobe divider and per-channel lanes together.
// Assumes in_stb marks input-rate sample periods and in_valid marks decimated samples.
module chan_rate_aligner
    import rmr_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int SMP_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH-1:0]             ch_en,
    input  logic [NCH-1:0][FAC_W-1:0]  dec_factor,
    input  logic [NCH-1:0]             in_valid,
    input  logic [NCH-1:0][SMP_W-1:0]  in_data,
    input  logic                       in_stb,
    output logic [NCH-1:0]             out_valid,
    output logic [NCH-1:0][SMP_W-1:0]  out_data,
    output logic [NCH-1:0][REP_W-1:0]  rep_factor,
    output logic                       cfg_error
);
    logic [NCH-1:0]             en_q;
    logic [NCH-1:0][FAC_W-1:0]  fac_q;
    logic                       recfg_q;
    logic                       chg, clr;
    logic                       legal, any_en, fire;
    logic [FAC_W-1:0]           min_fac;

    assign chg = (ch_en != en_q) || (dec_factor != fac_q);
    assign clr = chg || recfg_q;

    // Register the configuration and flag the cycle after a change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            fac_q   <= '0;
            recfg_q <= 1'b0;
        end else begin
            en_q    <= ch_en;
            fac_q   <= dec_factor;
            recfg_q <= chg;
        end
    end

    // Latch the error state of the registered configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_error <= 1'b0;
        else        cfg_error <= !legal;
    end

    rmr_cfg_check #(.NCH(NCH)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .fac     (fac_q),
        .legal   (legal),
        .any_en  (any_en),
        .min_fac (min_fac),
        .rep     (rep_factor)
    );

    rmr_stb_div u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .run    (legal && any_en),
        .in_stb (in_stb),
        .div    (min_fac),
        .fire   (fire)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        rmr_lane #(.SMP_W(SMP_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .quiet   (!legal),
            .en      (en_q[c]),
            .fire    (fire),
            .in_vld  (in_valid[c]),
            .in_smp  (in_data[c]),
            .out_vld (out_valid[c]),
            .out_smp (out_data[c])
        );
    end

    p_window_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        recfg_q |-> (out_valid == '0 && out_data == '0))
        else $error("output active in reconfiguration window");
    p_error_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |-> (out_valid == '0 && out_data == '0))
        else $error("output active while configuration illegal");
    p_pulse_after_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid) |-> $past(in_stb))
        else $error("output pulse without input strobe");
    p_none_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_q) == '0) |-> (out_valid == '0))
        else $error("pulse with no channel enabled");
endmodule

// File: tb/test_chan_rate_aligner.sv
module test_chan_rate_aligner;
    localparam int NCH = 8;
    localparam int SW  = 16;
    localparam int NV  = 11;
    localparam int WATCHDOG = 20000;

    typedef struct packed {
        logic [7:0]   en;
        logic [127:0] fac;   // ch7 .. ch0, 16 bits each
        logic         err;
        logic [111:0] rep;   // ch7 .. ch0, 14 bits each
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{8'h03, {{6{16'd2}}, 16'd16, 16'd4},     1'b0, {{6{14'd0}}, 14'd4, 14'd1}},       // R4 mixed pow2
        '{8'hFF, {8{16'd12}},                     1'b0, {8{14'd1}}},                       // R3 all equal base 3
        '{8'h05, {{5{16'd2}}, 16'd24, 16'd2, 16'd12}, 1'b1, {8{14'd0}}},                   // R3 mixed base 3
        '{8'h01, {{7{16'd2}}, 16'd7},             1'b1, {8{14'd0}}},                       // R2 out of set
        '{8'h03, {{6{16'd2}}, 16'd32768, 16'd2},  1'b1, {8{14'd0}}},                       // R5 ratio 16384
        '{8'h03, {{6{16'd2}}, 16'd32768, 16'd4},  1'b0, {{6{14'd0}}, 14'd8192, 14'd1}},    // R5 ratio 8192
        '{8'h06, {{5{16'd2}}, 16'd80, 16'd80, 16'd7}, 1'b0, {{5{14'd0}}, 14'd1, 14'd1, 14'd0}}, // R2 disabled bad factor
        '{8'hF0, {16'd1024, 16'd64, 16'd8, 16'd2, {4{16'd2}}}, 1'b0,
                 {14'd512, 14'd32, 14'd4, 14'd1, {4{14'd0}}}},                             // R4 four lanes
        '{8'h00, {8{16'd3}},                      1'b0, {8{14'd0}}},                       // R4 none enabled
        '{8'h03, {{6{16'd2}}, 16'd20, 16'd10},    1'b1, {8{14'd0}}},                       // R3 mixed base 5
        '{8'h03, {{6{16'd2}}, 16'd48, 16'd48},    1'b0, {{6{14'd0}}, 14'd1, 14'd1}}        // R3 equal base 3
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NCH-1:0]          ch_en = '0;
    logic [NCH-1:0][15:0]    dec_factor = '0;
    logic [NCH-1:0]          in_valid = '0;
    logic [NCH-1:0][SW-1:0]  in_data = '0;
    logic                    in_stb = 1'b0;
    logic [NCH-1:0]          out_valid;
    logic [NCH-1:0][SW-1:0]  out_data;
    logic [NCH-1:0][13:0]    rep_factor;
    logic                    cfg_error;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    chan_rate_aligner i_chan_rate_aligner (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .dec_factor(dec_factor),
        .in_valid(in_valid), .in_data(in_data), .in_stb(in_stb),
        .out_valid(out_valid), .out_data(out_data),
        .rep_factor(rep_factor), .cfg_error(cfg_error)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] en, input logic [127:0] fac);
        ch_en = en;
        dec_factor = fac;
        tick();
        tick();
    endtask

    // Hold in_stb high for n cycles; count pulses and collect data seen.
    task automatic run_stb(input int n, output int pulses, output logic [127:0] seen);
        pulses = 0;
        seen = '0;
        in_stb = 1'b1;
        for (int k = 0; k < n; k++) begin
            tick();
            if (|out_valid) pulses++;
            seen |= out_data;
        end
        in_stb = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int p;
        logic [127:0] s;
        // R1: reset state
        ch_en = 8'hFF;
        dec_factor = {8{16'd4}};
        repeat (3) tick();
        chk("R1 valid in reset", out_valid, '0);
        chk("R1 data in reset", out_data, '0);
        chk("R1 repeat in reset", rep_factor, '0);
        chk("R1 error in reset", cfg_error, 1'b0);
        ch_en = '0;
        dec_factor = '0;
        rst_n = 1'b1;
        tick();
        chk("R1 repeat after reset", rep_factor, '0);
        chk("R1 error after reset", cfg_error, 1'b0);

        // Table walk: legality and repeat readback
        for (int i = 0; i < NV; i++) begin
            ch_en = VEC[i].en;
            dec_factor = VEC[i].fac;
            tick();
            chk("R6 window valid", out_valid, '0);
            chk("R6 window data", out_data, '0);
            tick();
            chk("R2/R3/R5 cfg_error", cfg_error, VEC[i].err);
            chk("R4 repeat readback", rep_factor, VEC[i].rep);
        end

        // R8: capture and repeat; ch0 factor 2, ch1 factor 4, ch2 disabled
        apply(8'h03, {{6{16'd2}}, 16'd4, 16'd2});
        in_valid = 8'h07;
        in_data[0] = 16'hA001;
        in_data[1] = 16'hB002;
        in_data[2] = 16'h5555;
        tick();
        in_valid = '0;
        in_stb = 1'b1;
        tick();
        chk("R7 no pulse after first strobe", out_valid, '0);
        tick();
        in_stb = 1'b0;
        chk("R7 pulse on second strobe", out_valid, 8'h03);
        chk("R8 ch0 sample", out_data[0], 16'hA001);
        chk("R8 ch1 sample", out_data[1], 16'hB002);
        chk("R9 disabled lane data", out_data[2], '0);
        in_valid = 8'h05;
        in_data[0] = 16'hC003;
        tick();
        in_valid = '0;
        chk("R7 pulse lasts one cycle", out_valid, '0);
        chk("R8 hold between pulses", out_data[0], 16'hA001);
        in_stb = 1'b1;
        tick();
        tick();
        in_stb = 1'b0;
        chk("R8 ch0 new sample", out_data[0], 16'hC003);
        chk("R8 ch1 repeated sample", out_data[1], 16'hB002);
        chk("R9 disabled lane valid", out_valid[2], 1'b0);
        run_stb(8, p, s);
        chk("R7 pulses over 8 strobes at m=2", p, 4);
        // R8: capture on the pulse edge shows on the next pulse
        in_stb = 1'b1;
        tick();
        in_valid = 8'h01;
        in_data[0] = 16'hD004;
        tick();
        in_valid = '0;
        chk("R8 same-edge capture deferred", out_data[0], 16'hC003);
        tick();
        tick();
        in_stb = 1'b0;
        chk("R8 deferred sample appears", out_data[0], 16'hD004);

        // R6: reconfiguration clears held samples
        ch_en = 8'h01;
        tick();
        chk("R6 window clears data", out_data, '0);
        tick();
        in_stb = 1'b1;
        tick();
        tick();
        in_stb = 1'b0;
        chk("R6 pulse after reconfig", out_valid, 8'h01);
        chk("R6 held sample restarted", out_data[0], '0);

        // R7: m=4 over 12 strobes
        apply(8'h01, {{7{16'd2}}, 16'd4});
        run_stb(12, p, s);
        chk("R7 pulses over 12 strobes at m=4", p, 3);

        // R10: illegal configuration stays quiet, then recovers
        apply(8'h03, {{6{16'd2}}, 16'd6, 16'd2});
        chk("R10 error set", cfg_error, 1'b1);
        in_valid = 8'h03;
        in_data[0] = 16'hEEEE;
        run_stb(10, p, s);
        in_valid = '0;
        chk("R10 no pulses while illegal", p, 0);
        chk("R10 data zero while illegal", s, '0);
        apply(8'h03, {{6{16'd2}}, 16'd2, 16'd2});
        chk("R10 error cleared", cfg_error, 1'b0);
        run_stb(4, p, s);
        chk("R10 pulses after recovery", p, 2);

        // R11: nothing enabled
        apply(8'h00, {{6{16'd2}}, 16'd2, 16'd2});
        run_stb(10, p, s);
        chk("R11 no pulses with no channel", p, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule